// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a 32-bit virtual address to a physical address when a translation cache misses. It holds a table base, fetches a first-level descriptor from memory, and decodes it as a 1 MB section, a 16 MB supersection, a pointer to a coarse second-level table, or a fault. A coarse pointer leads to one more fetch, whose descriptor is decoded as a 4 KB small page, a 64 KB large page, or a fault.

Descriptors are read through a single-outstanding read port. The walker raises a request with an address and holds both until the memory answers with a one-cycle valid and data. At most one descriptor is in flight. A finished walk gives a one-cycle completion pulse together with the physical address, a page-size code and three attributes: endianness, element size and mixed size. A failed walk gives the same pulse with a fault flag and the faulting virtual address.

Large pages and supersections fill 16 identical consecutive descriptors in the table. The walker reads only the one that the virtual address selects, so the replication costs it nothing. It takes the page base from the upper descriptor bits and ignores the bits below them.

Top module: `xlat_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `rd_req`, `done`, `fault`, `pa`, `pg_size` are all 0.
- R2: Writing the base register keeps only bits 31:14 and drops the rest. The first fetch address is {base[31:14], va[31:20], 2'b00}.
- R3: A first-level descriptor with bits 1:0 = 2'b10 and bit 18 = 0 ends the walk as a 1 MB section: pa = {d[31:20], va[19:0]}, pg_size = 2.
- R4: A first-level descriptor with bits 1:0 = 2'b10 and bit 18 = 1 ends the walk as a 16 MB supersection: pa = {d[31:24], va[23:0]}, pg_size = 3. Descriptor bits 23:19 are ignored.
- R5: For first-level sections and supersections, `big_end` = d[15], `elem_sz` = d[11:10] and `mixed` = d[17].
- R6: A first-level descriptor with bits 1:0 = 2'b01 causes a second fetch at {d[31:10], va[19:12], 2'b00}.
- R7: A second-level descriptor with bit 1 = 1 (2'b10 or 2'b11) is a 4 KB page: pa = {d[31:12], va[11:0]}, pg_size = 0. A descriptor with bits 1:0 = 2'b01 is a 64 KB page: pa = {d[31:16], va[15:0]}, pg_size = 1, and bits 15:12 are ignored.
- R8: For second-level pages, `big_end` = d[9], `elem_sz` = d[5:4] and `mixed` = d[11].
- R9: A first-level descriptor with bits 1:0 of 2'b00 or 2'b11, or a second-level descriptor with bits 1:0 = 2'b00, ends the walk with `fault` = 1, `fault_va` = the walked virtual address, and `pa`, `pg_size` and the attributes all 0.
- R10: `rd_req` and `rd_addr` stay steady until `rd_valid`. No request is issued while idle. `done` is a one-cycle pulse. `req_valid` is ignored while a walk is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | Table base value; bits 13:0 dropped |
| req_valid | input | 1 | Start a walk for `req_va` (taken only when idle) |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to take a request |
| rd_req | output | 1 | Descriptor read request, held until answered |
| rd_addr | output | 32 | Descriptor byte address |
| rd_valid | input | 1 | One-cycle read response strobe |
| rd_data | input | 32 | Descriptor returned with `rd_valid` |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | Walk ended in a translation fault |
| pa | output | 32 | Translated physical address |
| pg_size | output | 2 | 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB |
| big_end | output | 1 | Endianness attribute of the page |
| elem_sz | output | 2 | Element-size attribute of the page |
| mixed | output | 1 | Mixed-size attribute of the page |
| fault_va | output | 32 | Virtual address of the last faulting walk |

## Verification
The assertions assume that memory raises `rd_valid` only while `rd_req` is high, and at most once for each request. Without that, the request-hold property and the offset checks would be judged against a descriptor the walker never asked for. The bench memory model keeps within this rule. It answers only a held request, two cycles after it appears, returns descriptors in fetch order, and drops `valid` at once after one cycle. The busy-request test drives `req_valid` during a walk, which the walker is required to ignore, so it stays within what the properties expect.

// File: rtl/xlat_walker.sv
module xlat_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_wr,
  input  logic [31:0] base_wdata,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  output logic        req_ready,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_valid,
  input  logic [31:0] rd_data,
  output logic        done,
  output logic        fault,
  output logic [31:0] pa,
  output logic [1:0]  pg_size,
  output logic        big_end,
  output logic [1:0]  elem_sz,
  output logic        mixed,
  output logic [31:0] fault_va
);
  localparam logic [1:0] SZ_4K = 2'd0, SZ_64K = 2'd1, SZ_1M = 2'd2, SZ_16M = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2} st_t;
  st_t st;

  logic [17:0] base_q;
  logic [21:0] coarse_q;
  logic [31:0] va_q;

  logic        fin, flt, n_end, n_mx;
  logic [1:0]  n_sz, n_el;
  logic [31:0] n_pa;

  assign req_ready = (st == S_IDLE);
  assign rd_req    = (st != S_IDLE);
  assign rd_addr   = (st == S_L2) ? {coarse_q, va_q[19:12], 2'b00}
                                  : {base_q, va_q[31:20], 2'b00};

  always_comb begin
    fin = 1'b0; flt = 1'b0; n_pa = '0; n_sz = SZ_4K;
    n_end = 1'b0; n_el = 2'b00; n_mx = 1'b0;
    if (st == S_L1 && rd_valid) begin
      if (rd_data[1:0] == 2'b10) begin
        fin   = 1'b1;
        n_end = rd_data[15];
        n_el  = rd_data[11:10];
        n_mx  = rd_data[17];
        if (rd_data[18]) begin
          n_pa = {rd_data[31:24], va_q[23:0]};
          n_sz = SZ_16M;
        end else begin
          n_pa = {rd_data[31:20], va_q[19:0]};
          n_sz = SZ_1M;
        end
      end else if (rd_data[1:0] != 2'b01) begin
        fin = 1'b1;
        flt = 1'b1;
      end
    end else if (st == S_L2 && rd_valid) begin
      fin = 1'b1;
      if (rd_data[1:0] == 2'b00) begin
        flt = 1'b1;
      end else begin
        n_end = rd_data[9];
        n_el  = rd_data[5:4];
        n_mx  = rd_data[11];
        if (rd_data[1]) begin
          n_pa = {rd_data[31:12], va_q[11:0]};
          n_sz = SZ_4K;
        end else begin
          n_pa = {rd_data[31:16], va_q[15:0]};
          n_sz = SZ_64K;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base_q <= '0; coarse_q <= '0; va_q <= '0;
      done <= 1'b0; fault <= 1'b0; pa <= '0; pg_size <= SZ_4K;
      big_end <= 1'b0; elem_sz <= 2'b00; mixed <= 1'b0; fault_va <= '0;
    end else begin
      done <= 1'b0;
      if (base_wr) base_q <= base_wdata[31:14];
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_va;
          st   <= S_L1;
        end
        S_L1: if (rd_valid && rd_data[1:0] == 2'b01) begin
          coarse_q <= rd_data[31:10];
          st       <= S_L2;
        end
        default: ;
      endcase
      if (fin) begin
        st      <= S_IDLE;
        done    <= 1'b1;
        fault   <= flt;
        pa      <= n_pa;
        pg_size <= n_sz;
        big_end <= n_end;
        elem_sz <= n_el;
        mixed   <= n_mx;
        if (flt) fault_va <= va_q;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_req);
  p_sect_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && pg_size == SZ_1M |-> pa[19:0] == va_q[19:0]);
  p_small_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && pg_size == SZ_4K |-> pa[11:0] == va_q[11:0]);
  p_fault_va_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> pa == 32'd0 && fault_va == va_q);
endmodule

// File: tb/sim_xlat_walker.sv
`timescale 1ns/1ps
module sim_xlat_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic base_wr = 1'b0, req_valid = 1'b0, rd_valid, req_ready, rd_req, done, fault, big_end, mixed;
  logic [31:0] base_wdata = '0, req_va = '0, rd_data, rd_addr, pa, fault_va;
  logic [1:0] pg_size, elem_sz;

  always #4 clk = ~clk;

  xlat_walker u0 (.clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .fault(fault),
    .pa(pa), .pg_size(pg_size), .big_end(big_end), .elem_sz(elem_sz), .mixed(mixed),
    .fault_va(fault_va));

  int total = 0, bad = 0;
  logic [31:0] mem_d1, mem_d2, seen1, seen2;
  int nfetch = 0;

  initial begin
    int cnt = 0;
    rd_valid = 1'b0; rd_data = '0; mem_d1 = '0; mem_d2 = '0; seen1 = '0; seen2 = '0;
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        rd_valid = 1'b0; cnt = 0;
      end else if (rd_req) begin
        cnt++;
        if (cnt >= 2) begin
          rd_valid = 1'b1;
          rd_data  = (nfetch == 0) ? mem_d1 : mem_d2;
          if (nfetch == 0) seen1 = rd_addr; else seen2 = rd_addr;
          nfetch++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  localparam int NV = 8;
  localparam logic [31:0] T_BASE [NV] = '{32'h8000_3FFF, 32'h8000_3FFF, 32'h8000_3FFF, 32'h0000_4123,
                                         32'h8000_3FFF, 32'h8000_3FFF, 32'h8000_3FFF, 32'h8000_3FFF};
  localparam logic [31:0] T_VA [NV]   = '{32'h1234_5678, 32'h1234_5678, 32'hFEDC_BA98, 32'h0001_2345,
                                         32'hC000_0000, 32'h0030_0001, 32'h0040_5000, 32'h0000_1FFF};
  localparam logic [31:0] T_D1 [NV]   = '{32'hABC2_8802, 32'hAB74_0402, 32'h1234_5401, 32'h0000_0C01,
                                         32'hFFFF_FFFC, 32'h1000_0003, 32'h2000_0001, 32'h3000_0001};
  localparam logic [31:0] T_D2 [NV]   = '{32'h0, 32'h0, 32'h5555_5A32, 32'h7777_9011,
                                         32'h0, 32'h0, 32'hFFFF_FFF0, 32'h4000_0003};
  localparam logic [31:0] T_A1 [NV]   = '{32'h8000_048C, 32'h8000_048C, 32'h8000_3FB4, 32'h0000_4000,
                                         32'h8000_3000, 32'h8000_000C, 32'h8000_0010, 32'h8000_0000};
  localparam logic [31:0] T_A2 [NV]   = '{32'h0, 32'h0, 32'h1234_572C, 32'h0000_0C48,
                                         32'h0, 32'h0, 32'h2000_0014, 32'h3000_0004};
  localparam int          T_NF [NV]   = '{1, 1, 2, 2, 1, 1, 2, 2};
  localparam bit          T_FLT [NV]  = '{0, 0, 0, 0, 1, 1, 1, 0};
  localparam logic [31:0] T_PA [NV]   = '{32'hABC4_5678, 32'hAB34_5678, 32'h5555_5A98, 32'h7777_2345,
                                         32'h0, 32'h0, 32'h0, 32'h4000_0FFF};
  localparam logic [1:0]  T_SZ [NV]   = '{2'd2, 2'd3, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0};
  localparam logic [3:0]  T_AT [NV]   = '{4'b1101, 4'b0010, 4'b1111, 4'b0010, 4'b0, 4'b0, 4'b0, 4'b0};
  localparam string       T_TAG [NV]  = '{"R3 R5 section", "R4 supersection", "R6 R7 R8 small",
                                         "R7 large", "R9 l1 fault 00", "R9 l1 fault 11",
                                         "R9 l2 fault", "R7 l2 code 11"};

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rd_req && !done && !fault && pa == 0 && pg_size == 0, "R1 reset state",
        {req_ready, rd_req, done, fault, pa[27:0]}, 32'h8000_0000);

    for (int v = 0; v < NV; v++) begin
      base_wr = 1'b1; base_wdata = T_BASE[v];
      @(negedge clk); base_wr = 1'b0;
      mem_d1 = T_D1[v]; mem_d2 = T_D2[v]; nfetch = 0; seen2 = '0;
      req_valid = 1'b1; req_va = T_VA[v];
      @(negedge clk); req_valid = 1'b0;
      wait_done(got);
      chk(got, {T_TAG[v], " done"}, {31'd0, got}, 32'd1);
      chk(seen1 == T_A1[v], {T_TAG[v], " R2 l1 addr"}, seen1, T_A1[v]);
      chk(nfetch == T_NF[v], {T_TAG[v], " fetch count"}, nfetch, T_NF[v]);
      if (T_NF[v] == 2) chk(seen2 == T_A2[v], {T_TAG[v], " l2 addr"}, seen2, T_A2[v]);
      chk(fault == T_FLT[v], {T_TAG[v], " fault"}, {31'd0, fault}, {31'd0, T_FLT[v]});
      chk(pa == T_PA[v], {T_TAG[v], " pa"}, pa, T_PA[v]);
      chk(pg_size == T_SZ[v], {T_TAG[v], " size"}, {30'd0, pg_size}, {30'd0, T_SZ[v]});
      chk({big_end, elem_sz, mixed} == T_AT[v], {T_TAG[v], " attrs"},
          {28'd0, big_end, elem_sz, mixed}, {28'd0, T_AT[v]});
      if (T_FLT[v]) chk(fault_va == T_VA[v], {T_TAG[v], " fault_va"}, fault_va, T_VA[v]);
      @(negedge clk);
      chk(!done, "R10 done pulse width", {31'd0, done}, 32'd0);
    end

    // R10: requests during a walk are ignored
    base_wr = 1'b1; base_wdata = 32'h8000_0000;
    @(negedge clk); base_wr = 1'b0;
    mem_d1 = 32'h1234_5401; mem_d2 = 32'h5555_5A32; nfetch = 0;
    req_valid = 1'b1; req_va = 32'hFEDC_BA98;
    @(negedge clk);
    chk(!req_ready, "R10 busy after accept", {31'd0, req_ready}, 32'd0);
    req_va = 32'h0BAD_0000;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_done(got);
    chk(got && pa == 32'h5555_5A98, "R10 busy request ignored pa", pa, 32'h5555_5A98);
    chk(seen1 == 32'h8000_3FB4, "R10 busy request ignored addr", seen1, 32'h8000_3FB4);
    repeat (4) @(negedge clk);
    chk(nfetch == 2 && req_ready && !rd_req, "R10 no extra walk", nfetch, 32'd2);

    // R9: fault_va holds the latest faulting address after a good walk
    chk(fault_va == 32'h0040_5000, "R9 fault_va retained", fault_va, 32'h0040_5000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule